// File: doc/BRIEF.md
# Row-Cached DRAM Access Controller

This block is a clock-synchronous model of a banked DRAM front end. Each bank has a one-row cache line and a tag that records which row of that bank was last fetched by a read. The row strobe, the column strobe and the other control pins are sampled on the system clock. A falling row strobe starts a cycle. The controller works out the cycle type from the write/read select, the refresh input and the chip select. It then compares the incoming row against the selected bank's tag, which gives one of five classes: read hit, read miss, write hit, write miss or refresh.

While the row strobe stays low, the low address bits act as the column address. Reads come straight from the active bank's cache line. Column writes are posted on any clock where both the column strobe and the write-data enable are low. A write hit updates both the DRAM row and the cache line. A write miss updates the DRAM row only, and read data stays switched off until a fixed number of clocks after the row strobe returns high. When a cycle ends, a precharge interval runs, and any row-strobe fall during that interval is ignored. The interval is shorter after a read hit than after any other cycle. The DRAM array is a small internal register array. Each row is stored as one wide word.

Top module: `rowcache_dram_ctrl`

## Requirements
- R1: The bank is `addr[BANK_W-1:0]` and the row tag is `addr[BANK_W+TAG_W-1:BANK_W]`. Reset marks every bank's tag invalid, so the first read of any bank is a read miss. A fetch into one bank leaves the tags of the other banks unchanged.
- R2: A read cycle (`write_cyc`=0) whose tag is valid and equal gives `cyc_kind`=1 (read hit). Its data comes from the cache, and after release `precharging` is high for PRE_SHORT clocks.
- R3: A read cycle that does not match gives `cyc_kind`=2 (read miss). The DRAM row is copied into the bank's cache line and that bank's tag is loaded, so the next read of the same row is a hit.
- R4: While a read cycle is active, `rdata` follows the column in `addr[COL_W-1:0]` with no new row access.
- R5: A write cycle (`write_cyc`=1) that matches gives `cyc_kind`=3 (write hit). Writes go to both the DRAM row and the cache line, and read data stays enabled, so the written value is readable on the clock after the write.
- R6: A write cycle that does not match gives `cyc_kind`=4 (write miss). Writes go to DRAM only, the cache line is unchanged, and `rdata_vld` is low throughout the cycle.
- R7: After a write miss ends, `rdata_vld` stays low for LOCK_CYC clocks whatever the value of `out_en_n`. `rdata` is zero whenever `rdata_vld` is low.
- R8: A column write happens only on a clock where `col_stb_n` and `wdat_en_n` are both low. A write cycle in which that never happens leaves the row's data unmodified.
- R9: A write fall with `col_stb_n` or `wdat_en_n` already low is not accepted (`cyc_kind` stays 0).
- R10: Write cycles, hit or miss, never change any tag.
- R11: A fall with `rfsh_n` low gives `cyc_kind`=5 (refresh) whatever the chip select. It leaves all tags and cache lines unchanged and is followed by PRE_LONG clocks of precharge.
- R12: A fall with `chip_sel_n` high and `rfsh_n` high is ignored (`cyc_kind` stays 0, no precharge follows).
- R13: After any cycle other than a read hit, `precharging` is high for PRE_LONG clocks. A row-strobe fall seen while `precharging` is high is ignored, and cache reads remain available during precharge.
- R14: `rdata_vld` is high exactly when `out_en_n` is low, no lockout is running and the cycle is not a write miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_stb_n | input | 1 | Row strobe, active low; its fall starts a cycle |
| col_stb_n | input | 1 | Column strobe, active low |
| wdat_en_n | input | 1 | Write-data enable, active low |
| write_cyc | input | 1 | 1 selects a write cycle, 0 a read cycle |
| rfsh_n | input | 1 | Refresh request, active low |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | BANK_W+TAG_W | Row address at the fall, column in low bits afterwards |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data from the active cache line, zero when disabled |
| rdata_vld | output | 1 | Read data driven |
| cyc_kind | output | 3 | 0 idle, 1 read hit, 2 read miss, 3 write hit, 4 write miss, 5 refresh |
| precharging | output | 1 | Precharge interval running |

## Verification
The bench builds the block with TAG_W=3, COL_W=2 and DATA_W=8. Rows are then five-bit addresses and each line holds four columns, so a hit row and a conflicting row of the same bank fit in one short table. PRE_SHORT=1, PRE_LONG=3 and LOCK_CYC=3 make the precharge and lockout intervals short enough that every clock of each one can be checked, including a fall that arrives during the one-clock read-hit precharge.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  typedef enum logic [2:0] {
    CY_IDLE    = 3'd0,
    CY_RD_HIT  = 3'd1,
    CY_RD_MISS = 3'd2,
    CY_WR_HIT  = 3'd3,
    CY_WR_MISS = 3'd4,
    CY_REFRESH = 3'd5
  } cyc_e;
endpackage

// File: rtl/rcd_classify.sv
module rcd_classify
  import rcd_pkg::*;
(
  input  logic fall,
  input  logic write_cyc,
  input  logic col_stb_n,
  input  logic wdat_en_n,
  input  logic rfsh_n,
  input  logic chip_sel_n,
  input  logic tag_hit,
  output cyc_e kind
);
  // Refresh wins over select; write needs both strobes idle at the fall.
  always_comb begin
    kind = CY_IDLE;
    if (fall) begin
      if (!rfsh_n)                      kind = CY_REFRESH;
      else if (chip_sel_n)              kind = CY_IDLE;
      else if (!write_cyc)              kind = tag_hit ? CY_RD_HIT : CY_RD_MISS;
      else if (!col_stb_n || !wdat_en_n) kind = CY_IDLE;
      else                              kind = tag_hit ? CY_WR_HIT : CY_WR_MISS;
    end
  end
endmodule

// File: rtl/rcd_store.sv
module rcd_store #(
  parameter int BANK_W = 2,
  parameter int TAG_W  = 9,
  parameter int COL_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BANK_W-1:0]         lk_bank,
  input  logic [TAG_W-1:0]          lk_tag,
  output logic                      tag_hit,
  input  logic                      ld_en,
  input  logic                      wr_en,
  input  logic                      wr_cache,
  input  logic [BANK_W+TAG_W-1:0]   wr_row,
  input  logic [COL_W-1:0]          wr_col,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [BANK_W-1:0]         rd_bank,
  input  logic [COL_W-1:0]          rd_col,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int BANKS    = 1 << BANK_W;
  localparam int ADDR_W   = BANK_W + TAG_W;
  localparam int NROWS    = 1 << ADDR_W;
  localparam int ROW_BITS = DATA_W << COL_W;

  logic [BANKS-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [BANKS-1:0]            valid_q, valid_d;
  logic [ROW_BITS-1:0]         dram [NROWS];
  logic [ROW_BITS-1:0]         line_w [BANKS];
  logic [ROW_BITS-1:0]         fetch_row;
  logic [BANK_W-1:0]           wr_bank;

  assign wr_bank   = wr_row[BANK_W-1:0];
  assign fetch_row = dram[{lk_tag, lk_bank}];
  assign tag_hit   = valid_q[lk_bank] && (tag_q[lk_bank] == lk_tag);

  // Tags: only a read fetch reloads them.
  always_comb begin
    tag_d   = tag_q;
    valid_d = valid_q;
    if (ld_en) begin
      tag_d[lk_bank]   = lk_tag;
      valid_d[lk_bank] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '0;
      valid_q <= '0;
    end else begin
      tag_q   <= tag_d;
      valid_q <= valid_d;
    end
  end

  // DRAM array: column-granular posted writes.
  always_ff @(posedge clk) begin
    if (wr_en) dram[wr_row][int'(wr_col)*DATA_W +: DATA_W] <= wr_data;
  end

  // One cache line per bank.
  for (genvar b = 0; b < BANKS; b++) begin : g_line
    logic [ROW_BITS-1:0] line_q;
    logic                line_ld, line_wr;
    assign line_ld = ld_en && (lk_bank == BANK_W'(b));
    assign line_wr = wr_en && wr_cache && (wr_bank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (line_ld)      line_q <= fetch_row;
      else if (line_wr) line_q[int'(wr_col)*DATA_W +: DATA_W] <= wr_data;
    end
    assign line_w[b] = line_q;
  end

  assign rd_data = line_w[rd_bank][int'(rd_col)*DATA_W +: DATA_W];

  // R10: tags hold across any clock carrying a column write
  p_tag_hold_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($stable(tag_q) && $stable(valid_q)));
  // R3: a fetch leaves the bank's tag valid and equal to the fetched row
  p_fetch_loads_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (valid_q[$past(lk_bank)] && tag_q[$past(lk_bank)] == $past(lk_tag)));
  // R1: no fetch, no tag change
  p_tag_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(valid_q));
endmodule

// File: rtl/rcd_timer.sv
module rcd_timer #(
  parameter int PRE_SHORT = 1,
  parameter int PRE_LONG  = 3,
  parameter int LOCK_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_pre,
  input  logic pre_short,
  input  logic start_lock,
  output logic busy,
  output logic locked
);
  localparam int PW = $clog2(PRE_LONG + 1);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [LW-1:0] lock_q, lock_d;

  always_comb begin
    if (start_pre)      pre_d = pre_short ? PW'(PRE_SHORT) : PW'(PRE_LONG);
    else if (pre_q != 0) pre_d = pre_q - 1'b1;
    else                pre_d = pre_q;
    if (start_lock)      lock_d = LW'(LOCK_CYC);
    else if (lock_q != 0) lock_d = lock_q - 1'b1;
    else                 lock_d = lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      lock_q <= '0;
    end else begin
      pre_q  <= pre_d;
      lock_q <= lock_d;
    end
  end

  assign busy   = (pre_q != 0);
  assign locked = (lock_q != 0);

  // R13: precharge only starts from a cycle end
  p_busy_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_pre) |=> !busy);
  // R7: lockout begins right after a write-miss end
  p_lock_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_lock |=> locked);
endmodule

// File: rtl/rowcache_dram_ctrl.sv
module rowcache_dram_ctrl
  import rcd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int TAG_W     = 9,
  parameter int COL_W     = 1,
  parameter int DATA_W    = 8,
  parameter int PRE_SHORT = 1,
  parameter int PRE_LONG  = 3,
  parameter int LOCK_CYC  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    row_stb_n,
  input  logic                    col_stb_n,
  input  logic                    wdat_en_n,
  input  logic                    write_cyc,
  input  logic                    rfsh_n,
  input  logic                    chip_sel_n,
  input  logic                    out_en_n,
  input  logic [BANK_W+TAG_W-1:0] addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output logic                    rdata_vld,
  output logic [2:0]              cyc_kind,
  output logic                    precharging
);
  localparam int ADDR_W = BANK_W + TAG_W;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  cyc_e              kind_q, kind_d, cls_kind;
  logic [ADDR_W-1:0] row_q, row_d;
  logic              rs_q;
  logic              fall, tag_hit, busy, locked;
  logic              start_pre, start_lock, ld_en, wr_en, wr_cache, in_write;
  logic [DATA_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rs_q <= 1'b1;
    else        rs_q <= row_stb_n;
  end

  assign fall = rs_q && !row_stb_n && !busy && (kind_q == CY_IDLE);

  rcd_classify i_classify (
    .fall       (fall),
    .write_cyc  (write_cyc),
    .col_stb_n  (col_stb_n),
    .wdat_en_n  (wdat_en_n),
    .rfsh_n     (rfsh_n),
    .chip_sel_n (chip_sel_n),
    .tag_hit    (tag_hit),
    .kind       (cls_kind)
  );

  // Next state: open on an accepted fall, close when the strobe rises.
  always_comb begin
    kind_d = kind_q;
    row_d  = row_q;
    if (kind_q == CY_IDLE) begin
      kind_d = cls_kind;
      if (cls_kind != CY_IDLE && cls_kind != CY_REFRESH) row_d = addr;
    end else if (row_stb_n) begin
      kind_d = CY_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      kind_q <= CY_IDLE;
      row_q  <= '0;
    end else begin
      kind_q <= kind_d;
      row_q  <= row_d;
    end
  end

  assign in_write   = (kind_q == CY_WR_HIT) || (kind_q == CY_WR_MISS);
  assign start_pre  = (kind_q != CY_IDLE) && row_stb_n;
  assign start_lock = (kind_q == CY_WR_MISS) && row_stb_n;
  assign ld_en      = (cls_kind == CY_RD_MISS);
  assign wr_en      = in_write && !row_stb_n && !col_stb_n && !wdat_en_n;
  assign wr_cache   = (kind_q == CY_WR_HIT);

  rcd_timer #(
    .PRE_SHORT (PRE_SHORT),
    .PRE_LONG  (PRE_LONG),
    .LOCK_CYC  (LOCK_CYC)
  ) i_timer (
    .clk        (clk),
    .rst_n      (rst_s),
    .start_pre  (start_pre),
    .pre_short  (kind_q == CY_RD_HIT),
    .start_lock (start_lock),
    .busy       (busy),
    .locked     (locked)
  );

  rcd_store #(
    .BANK_W (BANK_W),
    .TAG_W  (TAG_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) i_store (
    .clk      (clk),
    .rst_n    (rst_s),
    .lk_bank  (addr[BANK_W-1:0]),
    .lk_tag   (addr[ADDR_W-1:BANK_W]),
    .tag_hit  (tag_hit),
    .ld_en    (ld_en),
    .wr_en    (wr_en),
    .wr_cache (wr_cache),
    .wr_row   (row_q),
    .wr_col   (addr[COL_W-1:0]),
    .wr_data  (wdata),
    .rd_bank  (row_q[BANK_W-1:0]),
    .rd_col   (addr[COL_W-1:0]),
    .rd_data  (rd_data)
  );

  assign rdata_vld   = !out_en_n && !locked && (kind_q != CY_WR_MISS);
  assign rdata       = rdata_vld ? rd_data : '0;
  assign cyc_kind    = kind_q;
  assign precharging = busy;

  // R6: no read data during a write miss
  p_wmiss_dark_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (kind_q == CY_WR_MISS) |-> !rdata_vld);
  // R7: lockout keeps data off and zero
  p_lock_dark_r7: assert property (@(posedge clk) disable iff (!rst_s)
    locked |-> (!rdata_vld && rdata == '0));
  // R13: a fall during precharge opens no cycle
  p_busy_ignore_r13: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && rs_q && !row_stb_n) |=> (kind_q == CY_IDLE));
  // R12: deselected fall without refresh opens no cycle
  p_standby_r12: assert property (@(posedge clk) disable iff (!rst_s)
    (fall && chip_sel_n && rfsh_n) |=> (kind_q == CY_IDLE));
  // R14: output enable high forces data off
  p_oe_off_r14: assert property (@(posedge clk) disable iff (!rst_s)
    out_en_n |-> !rdata_vld);
  // R11: refresh leaves the cached row unchanged
  p_refresh_row_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (kind_q == CY_IDLE && cls_kind == CY_REFRESH) |=> $stable(row_q));
endmodule

// File: tb/test_rowcache_dram_ctrl.sv
`timescale 1ns/1ps
module test_rowcache_dram_ctrl;
  localparam int BANK_W = 2, TAG_W = 3, COL_W = 2, DATA_W = 8;
  localparam int AW = BANK_W + TAG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rs = 1'b1, cl = 1'b1, we = 1'b1, wr = 1'b0, rf = 1'b1, sl = 1'b0, oe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] rdata;
  logic rdata_vld, precharging;
  logic [2:0] cyc_kind;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rowcache_dram_ctrl #(
    .BANK_W(BANK_W), .TAG_W(TAG_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .PRE_SHORT(1), .PRE_LONG(3), .LOCK_CYC(3)
  ) i_rowcache_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .row_stb_n(rs), .col_stb_n(cl), .wdat_en_n(we),
    .write_cyc(wr), .rfsh_n(rf), .chip_sel_n(sl), .out_en_n(oe), .addr(addr),
    .wdata(din), .rdata(rdata), .rdata_vld(rdata_vld), .cyc_kind(cyc_kind),
    .precharging(precharging)
  );

  typedef struct packed {
    logic [3:0] rep;
    logic rs, wr, cl, we, rf, sl, oe;
    logic [4:0] addr;
    logic [7:0] din;
    logic [2:0] kind;
    logic en, bz, dc;
    logic [7:0] dout;
    logic [3:0] req;
  } vec_t;

  // rep rs wr cl we rf sl oe addr din    kind en bz dc dout   req
  localparam int NV = 38;
  localparam vec_t TBL [NV] = '{
    '{1, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,0,8'h00, 14}, // R14 idle, data on
    '{1, 0,1,1,1,1,0,0, 4, 8'h00, 4,0,0,0,8'h00, 6},  // R6 first write of bank 0 misses
    '{1, 0,1,0,0,1,0,0, 0, 8'hA1, 4,0,0,0,8'h00, 8},  // R8 write col0
    '{1, 0,1,0,0,1,0,0, 1, 8'hA2, 4,0,0,0,8'h00, 8},  // R8 write col1
    '{1, 0,1,1,0,1,0,0, 1, 8'hFF, 4,0,0,0,8'h00, 8},  // R8 column strobe high: no write
    '{1, 1,1,1,1,1,0,0, 0, 8'h00, 0,0,1,0,8'h00, 7},  // R7 lockout starts
    '{2, 1,0,1,1,1,0,0, 0, 8'h00, 0,0,1,0,8'h00, 7},  // R7 still locked
    '{1, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,0,8'h00, 7},  // R7 lockout over
    '{1, 0,0,1,1,1,0,0, 4, 8'h00, 2,1,0,1,8'hA1, 3},  // R3 read miss fetches row
    '{1, 0,0,1,1,1,0,0, 1, 8'h00, 2,1,0,1,8'hA2, 4},  // R4 column change
    '{1, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,1,1,8'hA1, 13}, // R13 reads during precharge
    '{3, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,0,8'h00, 13}, // R13 long precharge ends
    '{1, 0,0,1,1,1,0,0, 4, 8'h00, 1,1,0,1,8'hA1, 2},  // R2 read hit
    '{1, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,1,1,8'hA1, 2},  // R2 short precharge
    '{1, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,0,8'h00, 2},  // R2 short precharge over
    '{1, 0,1,1,1,1,0,0, 4, 8'h00, 3,1,0,1,8'hA1, 5},  // R5 write hit, reads on
    '{1, 0,1,0,0,1,0,0, 0, 8'hB1, 3,1,0,1,8'hB1, 5},  // R5 read-after-write
    '{1, 0,1,1,1,1,0,0, 1, 8'h00, 3,1,0,1,8'hA2, 5},  // R5 other column intact
    '{1, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,1,1,8'hB1, 13}, // R13 long after write
    '{3, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,0,8'h00, 13}, // R13
    '{1, 0,1,1,1,1,0,0, 8, 8'h00, 4,0,0,0,8'h00, 6},  // R6 conflicting row misses
    '{1, 0,1,0,0,1,0,0, 0, 8'hC1, 4,0,0,0,8'h00, 6},  // R6 write to DRAM only
    '{1, 1,0,1,1,1,0,0, 0, 8'h00, 0,0,1,0,8'h00, 7},  // R7
    '{3, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,1,8'hB1, 6},  // R6 cache line unchanged
    '{1, 0,0,1,1,1,0,0, 4, 8'h00, 1,1,0,1,8'hB1, 10}, // R10 tag kept by write miss
    '{2, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,1,8'hB1, 2},  // R2
    '{1, 0,0,1,1,1,0,0, 8, 8'h00, 2,1,0,1,8'hC1, 3},  // R3 miss fetches written row
    '{4, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,1,8'hC1, 13}, // R13
    '{1, 0,0,1,1,1,0,0, 4, 8'h00, 2,1,0,1,8'hB1, 5},  // R5 DRAM got write-hit data
    '{1, 0,0,1,1,1,0,0, 1, 8'h00, 2,1,0,1,8'hA2, 8},  // R8 unstrobed column kept
    '{4, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,0,8'h00, 13}, // R13
    '{1, 0,0,1,1,0,0,0, 8, 8'h00, 5,1,0,0,8'h00, 11}, // R11 refresh
    '{1, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,1,0,8'h00, 11}, // R11 long precharge
    '{3, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,0,8'h00, 11}, // R11
    '{1, 0,0,1,1,1,1,0, 8, 8'h00, 0,1,0,0,8'h00, 12}, // R12 deselected
    '{1, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,0,8'h00, 12}, // R12 no precharge
    '{1, 0,0,1,1,1,0,0, 4, 8'h00, 1,1,0,1,8'hB1, 11}, // R11 refresh left tag/line
    '{4, 1,0,1,1,1,0,0, 0, 8'h00, 0,1,0,0,8'h00, 2}   // R2
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic r, w, c, e, f, s, o, input logic [AW-1:0] a, input logic [7:0] d);
    rs = r; wr = w; cl = c; we = e; rf = f; sl = s; oe = o; addr = a; din = d;
  endtask

  task automatic do_reset();
    drive(1,0,1,1,1,0,0,0,0);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R14", "reset kind", cyc_kind, 0);
    check("R14", "reset busy", precharging, 0);
    check("R14", "reset vld", rdata_vld, 1);

    for (int v = 0; v < NV; v++) begin
      drive(TBL[v].rs, TBL[v].wr, TBL[v].cl, TBL[v].we, TBL[v].rf, TBL[v].sl, TBL[v].oe,
            TBL[v].addr, TBL[v].din);
      tick(TBL[v].rep);
      check($sformatf("R%0d", TBL[v].req), $sformatf("row%0d kind", v), cyc_kind, TBL[v].kind);
      check($sformatf("R%0d", TBL[v].req), $sformatf("row%0d vld", v), rdata_vld, TBL[v].en);
      check($sformatf("R%0d", TBL[v].req), $sformatf("row%0d busy", v), precharging, TBL[v].bz);
      if (TBL[v].dc)
        check($sformatf("R%0d", TBL[v].req), $sformatf("row%0d data", v), rdata, TBL[v].dout);
      if (!TBL[v].en)
        check("R7", $sformatf("row%0d data off", v), rdata, 0);
    end

    // R1: reset invalidates tags; banks are independent
    do_reset();
    drive(0,0,1,1,1,0,0,4,0); tick(1);
    check("R1", "bank0 miss after reset", cyc_kind, 2);
    drive(1,0,1,1,1,0,0,0,0); tick(4);
    drive(0,0,1,1,1,0,0,5,0); tick(1);
    check("R1", "bank1 first read miss", cyc_kind, 2);
    drive(1,0,1,1,1,0,0,0,0); tick(4);
    drive(0,0,1,1,1,0,0,4,0); tick(1);
    check("R1", "bank0 tag kept", cyc_kind, 1);
    check("R1", "bank0 data", rdata, 8'hB1);

    // R13: fall during short precharge ignored
    drive(1,0,1,1,1,0,0,0,0); tick(1);
    check("R13", "busy after hit", precharging, 1);
    drive(0,0,1,1,1,0,0,4,0); tick(1);
    check("R13", "fall in precharge ignored", cyc_kind, 0);
    tick(1);
    check("R13", "still idle", cyc_kind, 0);
    drive(1,0,1,1,1,0,0,0,0); tick(2);

    // R9: write fall with strobes low not accepted
    drive(0,1,0,1,1,0,0,4,0); tick(1);
    check("R9", "write fall column low", cyc_kind, 0);
    drive(1,0,1,1,1,0,0,0,0); tick(1);
    drive(0,1,1,0,1,0,0,4,0); tick(1);
    check("R9", "write fall data-enable low", cyc_kind, 0);
    drive(1,0,1,1,1,0,0,0,0); tick(1);
    check("R9", "no precharge", precharging, 0);

    // R14: output enable high
    drive(1,0,1,1,1,0,1,0,0); tick(1);
    check("R14", "oe high vld", rdata_vld, 0);
    check("R14", "oe high data", rdata, 0);

    // R11: refresh regardless of select
    drive(0,0,1,1,0,1,0,4,0); tick(1);
    check("R11", "refresh deselected", cyc_kind, 5);
    drive(1,0,1,1,1,0,0,0,0); tick(4);
    drive(0,0,1,1,1,0,0,4,0); tick(1);
    check("R11", "tag survives refresh", cyc_kind, 1);
    drive(1,0,1,1,1,0,0,0,0); tick(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule